// File: doc/BRIEF.md
# Port-Driven PRG/CHR Bank Mapper

This block turns the two byte-wide general-purpose I/O ports of a sound chip into memory bank address bits for a cartridge. Port A holds the CPU-side bank numbers. Its low field picks a 32 KiB program ROM bank seen over CPU `$8000-$FFFF`. Its high field picks an 8 KiB work RAM bank seen at `$6000-$7FFF`. Port B holds the pattern-memory bank numbers for the PPU side, and its top bit can also choose between ROM and RAM. A port that is not yet driving its pins is read as all ones. The last program bank is therefore live straight after reset, before software has set the port directions.

The pattern-memory layout depends on static configuration inputs: which CHR memories are fitted and whether four-screen nametables are requested. With both memories and four-screen, the PPU space is split into a RAM half and a ROM half, each 8 KiB wide. The block also drives the nametable A10 line. This line is either hardwired horizontal or vertical mirroring, or a software-controlled one-screen select taken from the top bit of one of the ports.

All results pass through one register stage, so a consumer sees them one clock after the addresses and port values are presented.

Top module: `portbank_mapper`

## Requirements
- R1: While `rst_n` is low, every output (chip selects, selects, addresses and `ciram_a10`) is zero.
- R2: Each output reflects the inputs sampled at the previous rising clock edge and does not change between edges.
- R3: A port whose output-enable input is 0 is treated as the all-ones value in every decode below.
- R4: `prg_rom_cs` equals CPU address bit 15. `prg_rom_addr` is always {port A bits [PRG_ROM_BANK_W-1:0], CPU address [14:0]}.
- R5: `prg_ram_cs` is 1 exactly when CPU address bits [15:13] are 3'b011. `prg_ram_addr` is always {port A top PRG_RAM_BANK_W bits, CPU address [12:0]}. Below `$6000` both chip selects are 0.
- R6: Unless both CHR memories are fitted, `chr_cs` is the inverse of PPU address bit 13. `chr_addr` is {zero-extended port B bits [CHR_BANK_W-1:0], PPU address [12:0]}. `chr_ram_sel` is 1 only when RAM is fitted and ROM is not.
- R7: With both CHR memories and four-screen clear, `chr_cs` and `chr_addr` follow R6, and `chr_ram_sel` equals the top bit of port B.
- R8: With both CHR memories and four-screen set, `chr_cs` is 1 for PPU addresses below `$3F00`. When PPU bit 12 is 0, `chr_ram_sel`=1 and `chr_addr` = {zero-extended port B top CHR_RAM_BANK_W bits, PPU bit 13, PPU bits [11:0]}. When PPU bit 12 is 1, `chr_ram_sel`=0 and the bank field is port B bits [CHR_BANK_W-1:0].
- R9: With `cfg_soft_mirror`=0, `ciram_a10` is PPU bit 10 when `cfg_hdr_vert`=1 (vertical) and PPU bit 11 when it is 0 (horizontal).
- R10: With `cfg_soft_mirror`=1, `ciram_a10` is the top bit of port B when `cfg_hdr_vert`=1, and the top bit of port A when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_a_data | input | PORT_W | Port A pin value |
| port_a_oe | input | 1 | Port A driving its pins (1) or in input mode (0) |
| port_b_data | input | PORT_W | Port B pin value |
| port_b_oe | input | 1 | Port B driving its pins (1) or in input mode (0) |
| cpu_addr | input | 16 | CPU bus address |
| ppu_addr | input | 14 | PPU bus address |
| cfg_soft_mirror | input | 1 | 1 selects software one-screen mirroring |
| cfg_hdr_vert | input | 1 | Header mirroring bit, 1 means vertical |
| cfg_four_screen | input | 1 | Four-screen layout requested |
| cfg_chr_rom | input | 1 | CHR ROM fitted |
| cfg_chr_ram | input | 1 | CHR RAM fitted |
| prg_rom_cs | output | 1 | Program ROM window hit |
| prg_rom_addr | output | PRG_ROM_BANK_W+15 | Program ROM address |
| prg_ram_cs | output | 1 | Work RAM window hit |
| prg_ram_addr | output | PRG_RAM_BANK_W+13 | Work RAM address |
| chr_cs | output | 1 | Pattern memory access |
| chr_ram_sel | output | 1 | 1 selects CHR RAM, 0 selects CHR ROM |
| chr_addr | output | max(CHR_BANK_W,CHR_RAM_BANK_W)+13 | Pattern memory address |
| ciram_a10 | output | 1 | Nametable A10 / one-screen select |

## Verification
Every result of this block is due exactly one rising edge after its inputs are presented. The bench changes inputs on a falling edge, computes the expected outputs from the requirements at that moment, and compares them on the following falling edge, after one register stage. In directed steps it also compares the outputs a moment after new inputs are driven, before the rising edge, and expects the previous values (R2). The same one-edge offset is built into the clocked properties, which compare each registered output with the value its inputs had one edge earlier.

// File: rtl/portbank_pkg.sv
package portbank_pkg;

   localparam int CPU_AW      = 16;
   localparam int PPU_AW      = 14;
   localparam int ROM_WIN_AW  = 15;
   localparam int RAM_WIN_AW  = 13;
   localparam int CHR_WIN_AW  = 13;
   localparam int NUM_PORTS   = 2;

   typedef struct packed {
      logic soft_mirror;
      logic hdr_vert;
      logic four_screen;
      logic chr_rom;
      logic chr_ram;
   } map_cfg_t;

   typedef enum logic [1:0] {
      CHR_SINGLE   = 2'd0,
      CHR_SWITCHED = 2'd1,
      CHR_SPLIT    = 2'd2
   } chr_mode_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic chr_mode_e chr_mode_of(input logic has_rom, input logic has_ram,
                                             input logic four_screen);
      if (has_rom && has_ram)
         return four_screen ? CHR_SPLIT : CHR_SWITCHED;
      return CHR_SINGLE;
   endfunction

endpackage

// File: rtl/gpio_port_resolve.sv
module gpio_port_resolve #(
   parameter int W = 8
) (
   input  logic         oe,
   input  logic [W-1:0] pin_value,
   output logic [W-1:0] eff_value
);
   // A port in input mode floats high on the board: read it as all ones.
   assign eff_value = oe ? pin_value : {W{1'b1}};
endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
   import portbank_pkg::*;
#(
   parameter int ROM_BANK_W = 4,
   parameter int RAM_BANK_W = 2,
   localparam int ROM_AW    = ROM_BANK_W + ROM_WIN_AW,
   localparam int RAM_AW    = RAM_BANK_W + RAM_WIN_AW
) (
   input  logic [ROM_BANK_W-1:0] rom_bank,
   input  logic [RAM_BANK_W-1:0] ram_bank,
   input  logic [CPU_AW-1:0]     cpu_addr,
   output logic                  rom_cs,
   output logic [ROM_AW-1:0]     rom_addr,
   output logic                  ram_cs,
   output logic [RAM_AW-1:0]     ram_addr
);
   always_comb begin
      rom_cs   = cpu_addr[CPU_AW-1];
      ram_cs   = (cpu_addr[CPU_AW-1 -: 3] == 3'b011);
      rom_addr = {rom_bank, cpu_addr[ROM_WIN_AW-1:0]};
      ram_addr = {ram_bank, cpu_addr[RAM_WIN_AW-1:0]};
   end
endmodule

// File: rtl/chr_window_map.sv
module chr_window_map
   import portbank_pkg::*;
#(
   parameter int BANK_W     = 5,
   parameter int RAM_BANK_W = 2,
   localparam int AW        = max_int(BANK_W, RAM_BANK_W) + CHR_WIN_AW,
   localparam int FIELD_W   = AW - CHR_WIN_AW,
   localparam int PAD_ROM   = FIELD_W - BANK_W,
   localparam int PAD_RAM   = FIELD_W - RAM_BANK_W
) (
   input  logic [BANK_W-1:0]     rom_bank,
   input  logic [RAM_BANK_W-1:0] ram_bank,
   input  logic                  sel_bit,
   input  logic                  has_rom,
   input  logic                  has_ram,
   input  logic                  four_screen,
   input  logic [PPU_AW-1:0]     ppu_addr,
   output logic                  cs,
   output logic                  ram_sel,
   output logic [AW-1:0]         addr
);
   logic [FIELD_W-1:0] rom_field;
   logic [FIELD_W-1:0] ram_field;
   chr_mode_e          mode;

   // Widen each bank field to the common address width.
   if (PAD_ROM > 0) begin : g_rom_pad
      assign rom_field = {{PAD_ROM{1'b0}}, rom_bank};
   end else begin : g_rom_flat
      assign rom_field = rom_bank;
   end

   if (PAD_RAM > 0) begin : g_ram_pad
      assign ram_field = {{PAD_RAM{1'b0}}, ram_bank};
   end else begin : g_ram_flat
      assign ram_field = ram_bank;
   end

   assign mode = chr_mode_of(has_rom, has_ram, four_screen);

   always_comb begin
      cs      = 1'b0;
      ram_sel = 1'b0;
      addr    = '0;
      unique case (mode)
         CHR_SPLIT: begin
            // Bit 12 splits each 8 KiB half; bit 13 becomes the in-bank MSB.
            ram_sel = ~ppu_addr[12];
            addr    = {(ppu_addr[12] ? rom_field : ram_field),
                       ppu_addr[13], ppu_addr[11:0]};
            cs      = (ppu_addr[13:8] != 6'h3F);
         end
         CHR_SWITCHED: begin
            ram_sel = sel_bit;
            addr    = {rom_field, ppu_addr[CHR_WIN_AW-1:0]};
            cs      = ~ppu_addr[13];
         end
         default: begin
            ram_sel = has_ram & ~has_rom;
            addr    = {rom_field, ppu_addr[CHR_WIN_AW-1:0]};
            cs      = ~ppu_addr[13];
         end
      endcase
   end
endmodule

// File: rtl/mirror_select.sv
module mirror_select (
   input  logic soft_mirror,
   input  logic hdr_vert,
   input  logic port_a_msb,
   input  logic port_b_msb,
   input  logic ppu_a11,
   input  logic ppu_a10,
   output logic a10
);
   always_comb begin
      if (soft_mirror)
         a10 = hdr_vert ? port_b_msb : port_a_msb;
      else
         a10 = hdr_vert ? ppu_a10 : ppu_a11;
   end
endmodule

// File: rtl/portbank_mapper.sv
module portbank_mapper
   import portbank_pkg::*;
#(
   parameter int PORT_W          = 8,
   parameter int PRG_ROM_BANK_W  = 4,
   parameter int PRG_RAM_BANK_W  = 2,
   parameter int CHR_BANK_W      = 5,
   parameter int CHR_RAM_BANK_W  = 2,
   localparam int PRG_ROM_AW     = PRG_ROM_BANK_W + ROM_WIN_AW,
   localparam int PRG_RAM_AW     = PRG_RAM_BANK_W + RAM_WIN_AW,
   localparam int CHR_AW         = max_int(CHR_BANK_W, CHR_RAM_BANK_W) + CHR_WIN_AW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PORT_W-1:0]     port_a_data,
   input  logic                  port_a_oe,
   input  logic [PORT_W-1:0]     port_b_data,
   input  logic                  port_b_oe,
   input  logic [CPU_AW-1:0]     cpu_addr,
   input  logic [PPU_AW-1:0]     ppu_addr,
   input  logic                  cfg_soft_mirror,
   input  logic                  cfg_hdr_vert,
   input  logic                  cfg_four_screen,
   input  logic                  cfg_chr_rom,
   input  logic                  cfg_chr_ram,
   output logic                  prg_rom_cs,
   output logic [PRG_ROM_AW-1:0] prg_rom_addr,
   output logic                  prg_ram_cs,
   output logic [PRG_RAM_AW-1:0] prg_ram_addr,
   output logic                  chr_cs,
   output logic                  chr_ram_sel,
   output logic [CHR_AW-1:0]     chr_addr,
   output logic                  ciram_a10
);
   localparam int PA_IDX = 0;
   localparam int PB_IDX = 1;

   // Elaboration-time parameter checks.
   if (PORT_W < 2 || PORT_W > 16) begin : g_bad_port_w
      $error("portbank_mapper: PORT_W must be in 2..16");
   end
   if (PRG_ROM_BANK_W < 1 || PRG_RAM_BANK_W < 1 ||
       PRG_ROM_BANK_W + PRG_RAM_BANK_W > PORT_W) begin : g_bad_prg_split
      $error("portbank_mapper: PRG fields must be non-empty and fit in port A");
   end
   if (CHR_BANK_W < 1 || CHR_RAM_BANK_W < 1 ||
       CHR_BANK_W + CHR_RAM_BANK_W > PORT_W) begin : g_bad_chr_split
      $error("portbank_mapper: CHR fields must be non-empty and fit in port B");
   end

   // Port resolution, one instance per port.
   logic [PORT_W-1:0] port_pins [NUM_PORTS];
   logic              port_oe   [NUM_PORTS];
   logic [PORT_W-1:0] port_eff  [NUM_PORTS];

   assign port_pins[PA_IDX] = port_a_data;
   assign port_pins[PB_IDX] = port_b_data;
   assign port_oe[PA_IDX]   = port_a_oe;
   assign port_oe[PB_IDX]   = port_b_oe;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      gpio_port_resolve #(.W(PORT_W)) u_resolve (
         .oe        (port_oe[p]),
         .pin_value (port_pins[p]),
         .eff_value (port_eff[p])
      );
   end

   // Middle bits of the ports may be left unused by a given field split.
   logic port_bits_unused;
   assign port_bits_unused = ^{port_eff[PA_IDX], port_eff[PB_IDX]};

   map_cfg_t cfg;
   assign cfg = '{soft_mirror: cfg_soft_mirror, hdr_vert: cfg_hdr_vert,
                  four_screen: cfg_four_screen, chr_rom: cfg_chr_rom,
                  chr_ram: cfg_chr_ram};

   // Combinational decode.
   logic                  nx_rom_cs;
   logic [PRG_ROM_AW-1:0] nx_rom_addr;
   logic                  nx_ram_cs;
   logic [PRG_RAM_AW-1:0] nx_ram_addr;
   logic                  nx_chr_cs;
   logic                  nx_chr_ram_sel;
   logic [CHR_AW-1:0]     nx_chr_addr;
   logic                  nx_a10;

   prg_window_map #(
      .ROM_BANK_W (PRG_ROM_BANK_W),
      .RAM_BANK_W (PRG_RAM_BANK_W)
   ) u_prg (
      .rom_bank (port_eff[PA_IDX][PRG_ROM_BANK_W-1:0]),
      .ram_bank (port_eff[PA_IDX][PORT_W-1 -: PRG_RAM_BANK_W]),
      .cpu_addr (cpu_addr),
      .rom_cs   (nx_rom_cs),
      .rom_addr (nx_rom_addr),
      .ram_cs   (nx_ram_cs),
      .ram_addr (nx_ram_addr)
   );

   chr_window_map #(
      .BANK_W     (CHR_BANK_W),
      .RAM_BANK_W (CHR_RAM_BANK_W)
   ) u_chr (
      .rom_bank    (port_eff[PB_IDX][CHR_BANK_W-1:0]),
      .ram_bank    (port_eff[PB_IDX][PORT_W-1 -: CHR_RAM_BANK_W]),
      .sel_bit     (port_eff[PB_IDX][PORT_W-1]),
      .has_rom     (cfg.chr_rom),
      .has_ram     (cfg.chr_ram),
      .four_screen (cfg.four_screen),
      .ppu_addr    (ppu_addr),
      .cs          (nx_chr_cs),
      .ram_sel     (nx_chr_ram_sel),
      .addr        (nx_chr_addr)
   );

   mirror_select u_mirror (
      .soft_mirror (cfg.soft_mirror),
      .hdr_vert    (cfg.hdr_vert),
      .port_a_msb  (port_eff[PA_IDX][PORT_W-1]),
      .port_b_msb  (port_eff[PB_IDX][PORT_W-1]),
      .ppu_a11     (ppu_addr[11]),
      .ppu_a10     (ppu_addr[10]),
      .a10         (nx_a10)
   );

   // Single output register stage.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prg_rom_cs   <= 1'b0;
         prg_rom_addr <= '0;
         prg_ram_cs   <= 1'b0;
         prg_ram_addr <= '0;
         chr_cs       <= 1'b0;
         chr_ram_sel  <= 1'b0;
         chr_addr     <= '0;
         ciram_a10    <= 1'b0;
      end else begin
         prg_rom_cs   <= nx_rom_cs;
         prg_rom_addr <= nx_rom_addr;
         prg_ram_cs   <= nx_ram_cs;
         prg_ram_addr <= nx_ram_addr;
         chr_cs       <= nx_chr_cs;
         chr_ram_sel  <= nx_chr_ram_sel;
         chr_addr     <= nx_chr_addr;
         ciram_a10    <= nx_a10;
      end
   end

endmodule

// File: rtl/portbank_mapper_chk.sv
module portbank_mapper_chk
   import portbank_pkg::*;
#(
   parameter int PORT_W          = 8,
   parameter int PRG_ROM_BANK_W  = 4,
   parameter int PRG_RAM_BANK_W  = 2,
   parameter int CHR_BANK_W      = 5,
   parameter int CHR_RAM_BANK_W  = 2,
   localparam int PRG_ROM_AW     = PRG_ROM_BANK_W + ROM_WIN_AW,
   localparam int PRG_RAM_AW     = PRG_RAM_BANK_W + RAM_WIN_AW,
   localparam int CHR_AW         = max_int(CHR_BANK_W, CHR_RAM_BANK_W) + CHR_WIN_AW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PORT_W-1:0]     port_a_data,
   input  logic                  port_a_oe,
   input  logic [PORT_W-1:0]     port_b_data,
   input  logic                  port_b_oe,
   input  logic [CPU_AW-1:0]     cpu_addr,
   input  logic [PPU_AW-1:0]     ppu_addr,
   input  logic                  cfg_soft_mirror,
   input  logic                  cfg_hdr_vert,
   input  logic                  cfg_four_screen,
   input  logic                  cfg_chr_rom,
   input  logic                  cfg_chr_ram,
   input  logic                  prg_rom_cs,
   input  logic [PRG_ROM_AW-1:0] prg_rom_addr,
   input  logic                  prg_ram_cs,
   input  logic [PRG_RAM_AW-1:0] prg_ram_addr,
   input  logic                  chr_cs,
   input  logic                  chr_ram_sel,
   input  logic [CHR_AW-1:0]     chr_addr,
   input  logic                  ciram_a10
);
   logic [PORT_W-1:0] a_seen, b_seen;
   logic              chk_inputs_unused;
   logic              split_mode;

   assign a_seen            = port_a_oe ? port_a_data : {PORT_W{1'b1}};
   assign b_seen            = port_b_oe ? port_b_data : {PORT_W{1'b1}};
   assign chk_inputs_unused = ^{a_seen, b_seen};
   assign split_mode        = cfg_chr_rom & cfg_chr_ram & cfg_four_screen;

   // R1: outputs held at zero during reset
   a_r1_reset_zero: assert property (@(posedge clk)
      !rst_n |-> (!prg_rom_cs && prg_rom_addr == '0 && !prg_ram_cs && prg_ram_addr == '0 &&
                  !chr_cs && !chr_ram_sel && chr_addr == '0 && !ciram_a10));

   // R4 (with R3): ROM bank from port A low field, one edge later
   a_r4_rom_map: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (prg_rom_cs == $past(cpu_addr[15])) &&
                (prg_rom_addr == $past({a_seen[PRG_ROM_BANK_W-1:0], cpu_addr[14:0]})));

   // R5: work RAM window and bank
   a_r5_ram_map: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:13] == 3'b011) |=>
         prg_ram_cs && (prg_ram_addr == $past({a_seen[PORT_W-1 -: PRG_RAM_BANK_W], cpu_addr[12:0]})));

   // R5: nothing selected below $6000
   a_r5_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:13] < 3'b011) |=> (!prg_rom_cs && !prg_ram_cs));

   // R8: palette area never selects pattern memory in the split layout
   a_r8_palette_off: assert property (@(posedge clk) disable iff (!rst_n)
      (split_mode && ppu_addr[13:8] == 6'h3F) |=> !chr_cs);

   // R8: RAM half of the split layout
   a_r8_split_ram: assert property (@(posedge clk) disable iff (!rst_n)
      (split_mode && !ppu_addr[12] && ppu_addr[13:8] != 6'h3F) |=>
         chr_cs && chr_ram_sel && (chr_addr[12:0] == $past({ppu_addr[13], ppu_addr[11:0]})));

   // R9: hardwired mirroring
   a_r9_hard_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_soft_mirror |=> (ciram_a10 == $past(cfg_hdr_vert ? ppu_addr[10] : ppu_addr[11])));

   // R10: software one-screen select
   a_r10_soft_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_soft_mirror |=> (ciram_a10 == $past(cfg_hdr_vert ? b_seen[PORT_W-1] : a_seen[PORT_W-1])));

endmodule

bind portbank_mapper portbank_mapper_chk #(
   .PORT_W         (PORT_W),
   .PRG_ROM_BANK_W (PRG_ROM_BANK_W),
   .PRG_RAM_BANK_W (PRG_RAM_BANK_W),
   .CHR_BANK_W     (CHR_BANK_W),
   .CHR_RAM_BANK_W (CHR_RAM_BANK_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .port_a_data     (port_a_data),
   .port_a_oe       (port_a_oe),
   .port_b_data     (port_b_data),
   .port_b_oe       (port_b_oe),
   .cpu_addr        (cpu_addr),
   .ppu_addr        (ppu_addr),
   .cfg_soft_mirror (cfg_soft_mirror),
   .cfg_hdr_vert    (cfg_hdr_vert),
   .cfg_four_screen (cfg_four_screen),
   .cfg_chr_rom     (cfg_chr_rom),
   .cfg_chr_ram     (cfg_chr_ram),
   .prg_rom_cs      (prg_rom_cs),
   .prg_rom_addr    (prg_rom_addr),
   .prg_ram_cs      (prg_ram_cs),
   .prg_ram_addr    (prg_ram_addr),
   .chr_cs          (chr_cs),
   .chr_ram_sel     (chr_ram_sel),
   .chr_addr        (chr_addr),
   .ciram_a10       (ciram_a10)
);

// File: tb/portbank_mapper_tb_top.sv
module portbank_mapper_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int PW  = 8;
   localparam int RB  = 4;
   localparam int MB  = 2;
   localparam int CB  = 5;
   localparam int CRB = 2;
   localparam int RA  = RB + 15;
   localparam int MA  = MB + 13;
   localparam int CF  = (CB > CRB) ? CB : CRB;
   localparam int CA  = CF + 13;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b1;
   logic [PW-1:0] pa = '0, pb = '0;
   logic          pa_oe = 1'b0, pb_oe = 1'b0;
   logic [15:0]   cpu = '0;
   logic [13:0]   ppu = '0;
   logic          c_soft = 0, c_vert = 0, c_four = 0, c_rom = 0, c_ram = 0;

   logic          rom_cs, ram_cs, chr_cs, chr_ram_sel, a10;
   logic [RA-1:0] rom_addr;
   logic [MA-1:0] ram_addr;
   logic [CA-1:0] chr_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   portbank_mapper #(
      .PORT_W(PW), .PRG_ROM_BANK_W(RB), .PRG_RAM_BANK_W(MB),
      .CHR_BANK_W(CB), .CHR_RAM_BANK_W(CRB)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .port_a_data(pa), .port_a_oe(pa_oe), .port_b_data(pb), .port_b_oe(pb_oe),
      .cpu_addr(cpu), .ppu_addr(ppu),
      .cfg_soft_mirror(c_soft), .cfg_hdr_vert(c_vert), .cfg_four_screen(c_four),
      .cfg_chr_rom(c_rom), .cfg_chr_ram(c_ram),
      .prg_rom_cs(rom_cs), .prg_rom_addr(rom_addr),
      .prg_ram_cs(ram_cs), .prg_ram_addr(ram_addr),
      .chr_cs(chr_cs), .chr_ram_sel(chr_ram_sel), .chr_addr(chr_addr),
      .ciram_a10(a10)
   );

   typedef struct {
      logic          rom_cs;
      logic [RA-1:0] rom_addr;
      logic          ram_cs;
      logic [MA-1:0] ram_addr;
      logic          chr_cs;
      logic          chr_ram_sel;
      logic [CA-1:0] chr_addr;
      logic          a10;
      string         rom_tag;
      string         chr_tag;
      string         mir_tag;
   } exp_t;

   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;
   exp_t last_exp;

   function automatic exp_t model();
      exp_t e;
      logic [PW-1:0] ea, eb;
      logic [CF-1:0] romf, ramf;
      ea = pa_oe ? pa : '1;
      eb = pb_oe ? pb : '1;
      romf = CF'(eb[CB-1:0]);
      ramf = CF'(eb[PW-1 -: CRB]);
      e.rom_cs   = cpu[15];
      e.rom_addr = {ea[RB-1:0], cpu[14:0]};
      e.ram_cs   = (cpu >= 16'h6000) && (cpu <= 16'h7FFF);
      e.ram_addr = {ea[PW-1 -: MB], cpu[12:0]};
      e.rom_tag  = pa_oe ? "R4" : "R3";
      if (c_rom && c_ram && c_four) begin
         e.chr_tag     = "R8";
         e.chr_cs      = (ppu < 14'h3F00);
         e.chr_ram_sel = (ppu[12] == 1'b0);
         e.chr_addr    = {(ppu[12] ? romf : ramf), ppu[13], ppu[11:0]};
      end else if (c_rom && c_ram) begin
         e.chr_tag     = "R7";
         e.chr_cs      = (ppu < 14'h2000);
         e.chr_ram_sel = eb[PW-1];
         e.chr_addr    = {romf, ppu[12:0]};
      end else begin
         e.chr_tag     = "R6";
         e.chr_cs      = (ppu < 14'h2000);
         e.chr_ram_sel = c_ram && !c_rom;
         e.chr_addr    = {romf, ppu[12:0]};
      end
      if (!pb_oe) e.chr_tag = {e.chr_tag, "/R3"};
      if (c_soft) begin
         e.mir_tag = "R10";
         e.a10     = c_vert ? eb[PW-1] : ea[PW-1];
      end else begin
         e.mir_tag = "R9";
         e.a10     = c_vert ? ppu[10] : ppu[11];
      end
      return e;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input exp_t e);
      chk(e.rom_tag, "prg_rom_cs",   32'(rom_cs),      32'(e.rom_cs));
      chk(e.rom_tag, "prg_rom_addr", 32'(rom_addr),    32'(e.rom_addr));
      chk("R5",      "prg_ram_cs",   32'(ram_cs),      32'(e.ram_cs));
      chk("R5",      "prg_ram_addr", 32'(ram_addr),    32'(e.ram_addr));
      chk(e.chr_tag, "chr_cs",       32'(chr_cs),      32'(e.chr_cs));
      chk(e.chr_tag, "chr_ram_sel",  32'(chr_ram_sel), 32'(e.chr_ram_sel));
      chk(e.chr_tag, "chr_addr",     32'(chr_addr),    32'(e.chr_addr));
      chk(e.mir_tag, "ciram_a10",    32'(a10),         32'(e.a10));
   endtask

   // Drive on a falling edge, compare on the next falling edge (one register stage).
   task automatic apply(input logic [PW-1:0] a, input logic aoe,
                        input logic [PW-1:0] b, input logic boe,
                        input logic [15:0] c, input logic [13:0] p,
                        input logic [4:0] cfg, input bit hold_chk);
      exp_t e;
      pa = a; pa_oe = aoe; pb = b; pb_oe = boe; cpu = c; ppu = p;
      {c_soft, c_vert, c_four, c_rom, c_ram} = cfg;
      e = model();
      if (hold_chk) begin
         #1;
         // R2: before the next rising edge the outputs keep their earlier values
         chk("R2", "hold prg_rom_addr", 32'(rom_addr), 32'(last_exp.rom_addr));
         chk("R2", "hold chr_addr",     32'(chr_addr), 32'(last_exp.chr_addr));
      end
      @(negedge clk);
      check_all(e);
      last_exp = e;
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      #1 rst_n = 1'b0;
      pa = 8'hA5; pa_oe = 1'b1; cpu = 16'hC123; ppu = 14'h0ABC; c_rom = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "prg_rom_cs",   32'(rom_cs),   32'd0);
      chk("R1", "prg_rom_addr", 32'(rom_addr), 32'd0);
      chk("R1", "prg_ram_cs",   32'(ram_cs),   32'd0);
      chk("R1", "chr_cs",       32'(chr_cs),   32'd0);
      chk("R1", "chr_addr",     32'(chr_addr), 32'd0);
      chk("R1", "ciram_a10",    32'(a10),      32'd0);
      rst_n = 1'b1;

      // R3: both ports in input mode, last ROM bank at the vector area
      apply(8'h00, 1'b0, 8'h00, 1'b0, 16'hFFFC, 14'h0000, 5'b10000, 1'b0);
      // R4: bank 3, low ROM address
      apply(8'h03, 1'b1, 8'h00, 1'b1, 16'h8000, 14'h1FFF, 5'b00001, 1'b1);
      // R5: window edges
      apply(8'hC0, 1'b1, 8'h00, 1'b1, 16'h6000, 14'h2000, 5'b00010, 1'b1);
      apply(8'h40, 1'b1, 8'h00, 1'b1, 16'h7FFF, 14'h0000, 5'b00010, 1'b0);
      apply(8'hFF, 1'b1, 8'h00, 1'b1, 16'h5FFF, 14'h0000, 5'b00010, 1'b0);
      // R6: RAM only
      apply(8'h00, 1'b1, 8'h1F, 1'b1, 16'h0000, 14'h1234, 5'b00001, 1'b0);
      // R7: both present, top bit of port B picks RAM then ROM
      apply(8'h00, 1'b1, 8'h85, 1'b1, 16'h0000, 14'h0800, 5'b00011, 1'b1);
      apply(8'h00, 1'b1, 8'h05, 1'b1, 16'h0000, 14'h0800, 5'b00011, 1'b0);
      // R8: split layout corners
      apply(8'h00, 1'b1, 8'hC9, 1'b1, 16'h0000, 14'h0000, 5'b00111, 1'b1);
      apply(8'h00, 1'b1, 8'hC9, 1'b1, 16'h0000, 14'h1000, 5'b00111, 1'b0);
      apply(8'h00, 1'b1, 8'hC9, 1'b1, 16'h0000, 14'h2FFF, 5'b00111, 1'b0);
      apply(8'h00, 1'b1, 8'hC9, 1'b1, 16'h0000, 14'h3000, 5'b00111, 1'b0);
      apply(8'h00, 1'b1, 8'hC9, 1'b1, 16'h0000, 14'h3EFF, 5'b00111, 1'b0);
      apply(8'h00, 1'b1, 8'hC9, 1'b1, 16'h0000, 14'h3F00, 5'b00111, 1'b0);
      // R9: hardwired horizontal and vertical
      apply(8'h00, 1'b1, 8'h00, 1'b1, 16'h0000, 14'h2800, 5'b00010, 1'b0);
      apply(8'h00, 1'b1, 8'h00, 1'b1, 16'h0000, 14'h2400, 5'b01010, 1'b1);
      // R10: one-screen from port A then port B
      apply(8'h80, 1'b1, 8'h00, 1'b1, 16'h0000, 14'h2000, 5'b10010, 1'b1);
      apply(8'h80, 1'b1, 8'h00, 1'b1, 16'h0000, 14'h2000, 5'b11010, 1'b1);
      apply(8'h00, 1'b1, 8'h00, 1'b0, 16'h0000, 14'h2000, 5'b11010, 1'b0);

      // Random mix
      for (int i = 0; i < 3000; i++) begin
         apply(PW'($urandom), ($urandom_range(3) != 0), PW'($urandom), ($urandom_range(3) != 0),
               16'($urandom), 14'($urandom), 5'($urandom), (i % 7 == 0));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule